// File: doc/BRIEF.md
# Polygon Parameter Stream Decoder

The decoder takes a host stream of 32-bit words. Every eight words form one parameter packet. The first word of each packet is a control word, and bits 31:29 of that word give the packet type. A global packet sets the instruction words for the polygons that follow. Vertex packets are then chained into triangle strips. The decoder sends those strips out one vertex per beat, and each beat carries the current instruction words. An end-of-list packet closes the list.

A rasterizer downstream can only take strips of a limited size. The decoder therefore cuts strips that are longer than `MAX_TRI` triangles into several hardware strips. Each new hardware strip starts by replaying the last two vertices of the previous one, so no triangle is lost at the seam.

The block also rewrites the shading flag of the instruction word. It takes the value from the global packet header, not from the word the host supplied.

Both stream edges use valid/ready. An input word is taken on a clock edge where `in_valid` and `in_ready` are both high. An output beat is taken on an edge where `out_valid` and `out_ready` are both high. While a beat is held back, its payload does not change.

`in_ready` stays high through every word of a packet. It falls only after the last word of a packet has been taken, while the decoder works through the result of that packet. So a stalled output never splits a packet.

Top module: `param_strip_decoder`

## Requirements
- R1: A packet is exactly eight consecutive accepted words. `in_ready` never drops between the first and eighth word of a packet. A dropped or erroneous packet does not disturb the framing of the packets that follow.
- R2: The packet type is word-0 bits 31:29, with 0 = end of list, 4 = global, 7 = vertex. Any other code sets the sticky `err` output, and the packet is discarded without producing a beat.
- R3: A global packet latches word 1 as the ISP word, word 2 as the TSP word and word 3 as the texture word. Its control bits 26:24 appear on `out_list`. These values go out with every later beat.
- R4: Bit 23 of `out_isp` always equals control bit 1 of the global packet in force. Whatever the host put in bit 23 of word 1 has no effect.
- R5: A global packet whose colour-type field (control bits 5:4) is not 0 (packed colour) sets `err` and is discarded. The previous global stays in force.
- R6: A vertex packet supplies X, Y, Z and colour from words 1, 2, 3 and 6. A vertex that arrives while no global is in force sets `err` and produces no beat.
- R7: Each vertex of a strip is emitted once, in arrival order. `out_last` is set on the vertex whose control bit 28 (end of strip) is 1.
- R8: A hardware strip holds at most `MAX_TRI`+2 vertices (8 by default). When an input strip is longer, the current hardware strip ends with `out_last`, and the next one begins with the last two vertices already sent.
- R9: A global packet that arrives while a strip is open first closes that strip. The held vertex is emitted with `out_last`, still carrying the old instruction words.
- R10: An end-of-list packet first closes any open strip. It then raises `list_done` for exactly one cycle and clears the global state, so a vertex sent after it counts as an error.
- R11: While `out_valid` is high and `out_ready` is low, every output holds steady. While `out_valid` is high, `in_ready` is low.
- R12: After reset, `in_ready` is 1 and `out_valid`, `list_done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word may be accepted |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_x | output | 32 | Vertex X |
| out_y | output | 32 | Vertex Y |
| out_z | output | 32 | Vertex Z |
| out_color | output | 32 | Vertex packed colour |
| out_isp | output | 32 | ISP word, shading bit patched |
| out_tsp | output | 32 | TSP word |
| out_tex | output | 32 | Texture word |
| out_list | output | 3 | List type of current global |
| out_last | output | 1 | Final vertex of a hardware strip |
| list_done | output | 1 | One-cycle end-of-list pulse |
| err | output | 1 | Sticky protocol error |

## Verification
Suppose the word counter drifts. The very next packet is then decoded from the wrong control word, and the result shows up as `err` or as missing beats. Any of these faults is visible within one or two beats of the cycle that caused it:

- a chunk counter that is off by one moves the `out_last` position;
- a history register that is updated at the wrong moment shows up as the wrong vertex IDs in the replayed seam pair;
- a global applied too early shows up as new instruction words on a vertex that is being flushed.

The directed scenarios send strips of 3, 10 and 16 vertices under a random-looking stall pattern. They also cover a global arriving in the middle of a strip and a flush triggered by end of list. Each scenario compares every emitted beat against a reference strip model.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int PKT_WORDS   = 8;
  localparam int TYPE_LSB    = 29;
  localparam int EOS_BIT     = 28;
  localparam int LIST_LSB    = 24;
  localparam int SHADE_BIT   = 23;
  localparam int COLT_LSB    = 4;
  localparam int GOURAUD_BIT = 1;

  localparam logic [2:0] PT_EOL    = 3'd0;
  localparam logic [2:0] PT_GLOBAL = 3'd4;
  localparam logic [2:0] PT_VERTEX = 3'd7;

  typedef struct packed {
    logic [31:0] x;
    logic [31:0] y;
    logic [31:0] z;
    logic [31:0] color;
  } vtx_t;

  typedef enum logic [2:0] {
    S_RX, S_PEND, S_REP2, S_REP1, S_NEW, S_FLUSH, S_DONE
  } seq_state_e;
endpackage

// File: rtl/psd_rx.sv
module psd_rx
  import psd_pkg::*;
#(
  parameter int WORDS = PKT_WORDS,
  localparam int CW = $clog2(WORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [31:0]              in_data,
  input  logic                     accept,
  output logic                     in_ready,
  output logic                     pkt_done,
  output logic [CW-1:0]            wcnt,
  output logic [WORDS-2:0][31:0]   words
);
  logic take;
  logic at_end;

  assign in_ready = accept;
  assign take     = in_valid && in_ready;
  assign at_end   = (wcnt == CW'(WORDS - 1));
  assign pkt_done = take && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (take) begin
      wcnt <= at_end ? '0 : wcnt + CW'(1);
    end
  end

  // the last word of a packet is padding and is never stored
  for (genvar k = 0; k < WORDS - 1; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[k] <= '0;
      end else if (take && wcnt == CW'(k)) begin
        words[k] <= in_data;
      end
    end
  end
endmodule

// File: rtl/psd_glob.sv
module psd_glob
  import psd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        clear,
  input  logic [31:0] ctrl,
  input  logic [31:0] isp_in,
  input  logic [31:0] tsp_in,
  input  logic [31:0] tex_in,
  output logic        valid,
  output logic [31:0] isp,
  output logic [31:0] tsp,
  output logic [31:0] tex,
  output logic [2:0]  list_t
);
  logic [31:0] isp_patched;
  logic        unused_ctrl;

  assign unused_ctrl = ^{ctrl[31:27], ctrl[23:2], ctrl[0]};

  always_comb begin
    isp_patched            = isp_in;
    isp_patched[SHADE_BIT] = ctrl[GOURAUD_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      valid  <= 1'b0;
      isp    <= '0;
      tsp    <= '0;
      tex    <= '0;
      list_t <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      isp    <= isp_patched;
      tsp    <= tsp_in;
      tex    <= tex_in;
      list_t <= ctrl[LIST_LSB +: 3];
    end
  end
endmodule

// File: rtl/psd_seq.sv
module psd_seq
  import psd_pkg::*;
#(
  parameter int MAX_TRI = 6,
  localparam int MAXV = MAX_TRI + 2,
  localparam int CNT_W = $clog2(MAXV + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pkt_done,
  input  logic [31:0] w_ctrl,
  input  logic [31:0] w_x,
  input  logic [31:0] w_y,
  input  logic [31:0] w_z,
  input  logic [31:0] w_col,
  input  logic        glob_valid,
  output logic        accept,
  output logic        glob_load,
  output logic        glob_clear,
  output logic        out_valid,
  input  logic        out_ready,
  output vtx_t        out_vtx,
  output logic        out_last,
  output logic        list_done,
  output logic        err
);
  seq_state_e       st;
  vtx_t             cur, pend, e1, e2;
  logic             pend_v, flush_glob, err_q, fire, at_max, eos;
  logic [2:0]       ptype;
  logic [1:0]       colt;
  logic [CNT_W-1:0] cnt;
  logic             unused_ctrl;

  assign unused_ctrl = ^{w_ctrl[27:6], w_ctrl[3:0]};
  assign cur    = '{x: w_x, y: w_y, z: w_z, color: w_col};
  assign ptype  = w_ctrl[TYPE_LSB +: 3];
  assign eos    = w_ctrl[EOS_BIT];
  assign colt   = w_ctrl[COLT_LSB +: 2];
  assign fire   = out_valid && out_ready;
  assign at_max = (cnt == CNT_W'(MAXV - 1));

  always_comb begin
    out_valid = 1'b0;
    out_vtx   = pend;
    out_last  = 1'b0;
    case (st)
      S_PEND:  begin out_valid = 1'b1; out_last = at_max; end
      S_REP2:  begin out_valid = 1'b1; out_vtx = e2; end
      S_REP1:  begin out_valid = 1'b1; out_vtx = e1; end
      S_NEW:   begin out_valid = eos; out_vtx = cur; out_last = 1'b1; end
      S_FLUSH: begin out_valid = 1'b1; out_last = 1'b1; end
      default: ;
    endcase
  end

  assign accept     = (st == S_RX);
  assign glob_load  = (st == S_RX && pkt_done && ptype == PT_GLOBAL &&
                       colt == 2'd0 && !pend_v) ||
                      (st == S_FLUSH && fire && flush_glob);
  assign glob_clear = (st == S_DONE);
  assign list_done  = (st == S_DONE);
  assign err        = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_RX;
      pend       <= '0;
      e1         <= '0;
      e2         <= '0;
      pend_v     <= 1'b0;
      flush_glob <= 1'b0;
      err_q      <= 1'b0;
      cnt        <= '0;
    end else begin
      case (st)
        S_RX: if (pkt_done) begin
          case (ptype)
            PT_VERTEX: begin
              if (!glob_valid) err_q <= 1'b1;
              else             st    <= pend_v ? S_PEND : S_NEW;
            end
            PT_GLOBAL: begin
              if (colt != 2'd0) err_q <= 1'b1;
              else if (pend_v) begin
                flush_glob <= 1'b1;
                st         <= S_FLUSH;
              end
            end
            PT_EOL: begin
              flush_glob <= 1'b0;
              st         <= pend_v ? S_FLUSH : S_DONE;
            end
            default: err_q <= 1'b1;
          endcase
        end
        S_PEND: if (fire) begin
          e2     <= e1;
          e1     <= pend;
          pend_v <= 1'b0;
          if (at_max) begin
            cnt <= '0;
            st  <= S_REP2;
          end else begin
            cnt <= cnt + CNT_W'(1);
            st  <= S_NEW;
          end
        end
        S_REP2: if (fire) st <= S_REP1;
        S_REP1: if (fire) begin
          cnt <= CNT_W'(2);
          st  <= S_NEW;
        end
        S_NEW: begin
          if (eos) begin
            if (fire) begin
              cnt <= '0;
              st  <= S_RX;
            end
          end else begin
            pend   <= cur;
            pend_v <= 1'b1;
            st     <= S_RX;
          end
        end
        S_FLUSH: if (fire) begin
          pend_v <= 1'b0;
          cnt    <= '0;
          st     <= flush_glob ? S_RX : S_DONE;
        end
        S_DONE: begin
          cnt <= '0;
          st  <= S_RX;
        end
        default: st <= S_RX;
      endcase
    end
  end
endmodule

// File: rtl/param_strip_decoder.sv
module param_strip_decoder
  import psd_pkg::*;
#(
  parameter int MAX_TRI = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_x,
  output logic [31:0] out_y,
  output logic [31:0] out_z,
  output logic [31:0] out_color,
  output logic [31:0] out_isp,
  output logic [31:0] out_tsp,
  output logic [31:0] out_tex,
  output logic [2:0]  out_list,
  output logic        out_last,
  output logic        list_done,
  output logic        err
);
  localparam int CW = $clog2(PKT_WORDS);

  logic                        accept, pkt_done, glob_load, glob_clear, glob_valid;
  logic [CW-1:0]               rx_wcnt;
  logic [PKT_WORDS-2:0][31:0]  words;
  vtx_t                        vtx;
  logic                        unused_words;

  assign unused_words = ^{words[4], words[5]};

  psd_rx #(.WORDS(PKT_WORDS)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .accept(accept), .in_ready(in_ready), .pkt_done(pkt_done),
    .wcnt(rx_wcnt), .words(words)
  );

  psd_glob u_glob (
    .clk(clk), .rst_n(rst_n), .load(glob_load), .clear(glob_clear),
    .ctrl(words[0]), .isp_in(words[1]), .tsp_in(words[2]), .tex_in(words[3]),
    .valid(glob_valid), .isp(out_isp), .tsp(out_tsp), .tex(out_tex),
    .list_t(out_list)
  );

  psd_seq #(.MAX_TRI(MAX_TRI)) u_seq (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .w_ctrl(words[0]),
    .w_x(words[1]), .w_y(words[2]), .w_z(words[3]), .w_col(words[6]),
    .glob_valid(glob_valid), .accept(accept), .glob_load(glob_load),
    .glob_clear(glob_clear), .out_valid(out_valid), .out_ready(out_ready),
    .out_vtx(vtx), .out_last(out_last), .list_done(list_done), .err(err)
  );

  assign out_x     = vtx.x;
  assign out_y     = vtx.y;
  assign out_z     = vtx.z;
  assign out_color = vtx.color;
endmodule

// File: rtl/param_strip_decoder_chk.sv
module param_strip_decoder_chk #(
  parameter int MAX_TRI = 6,
  localparam int MAXV = MAX_TRI + 2,
  localparam int CNT_W = $clog2(MAXV + 1)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_x,
  input logic        out_last,
  input logic        list_done,
  input logic        err,
  input logic [2:0]  wcnt
);
  logic [CNT_W-1:0] beats;

  always_ff @(posedge clk) begin
    if (!rst_n) beats <= '0;
    else if (out_valid && out_ready) beats <= out_last ? '0 : beats + CNT_W'(1);
  end

  // R1
  mid_pkt_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt != 3'd0) |-> in_ready);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_last)));

  // R11
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |=> !list_done);

  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8
  chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (beats < CNT_W'(MAXV)));
endmodule

bind param_strip_decoder param_strip_decoder_chk #(.MAX_TRI(MAX_TRI)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_x(out_x), .out_last(out_last),
  .list_done(list_done), .err(err), .wcnt(rx_wcnt)
);

// File: tb/param_strip_decoder_test.sv
module param_strip_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_last, list_done, err;
  logic [31:0] out_x, out_y, out_z, out_color, out_isp, out_tsp, out_tex;
  logic [2:0]  out_list;

  int checks = 0, fails = 0;
  int nb = 0, ne = 0, done_cnt = 0, rdy_viol = 0, bp_ctr = 0;
  bit bp = 1'b0;
  logic [31:0] g_x[64], g_y[64], g_z[64], g_c[64], g_isp[64], g_tsp[64], g_tex[64];
  logic [2:0]  g_list[64];
  bit          g_last[64];
  int          e_id[64];
  bit          e_last[64];

  always #5 clk = ~clk;

  param_strip_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_z(out_z), .out_color(out_color),
    .out_isp(out_isp), .out_tsp(out_tsp), .out_tex(out_tex),
    .out_list(out_list), .out_last(out_last), .list_done(list_done), .err(err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && nb < 64) begin
        g_x[nb] = out_x; g_y[nb] = out_y; g_z[nb] = out_z; g_c[nb] = out_color;
        g_isp[nb] = out_isp; g_tsp[nb] = out_tsp; g_tex[nb] = out_tex;
        g_list[nb] = out_list; g_last[nb] = out_last;
        nb++;
      end
      if (list_done) done_cnt++;
      if (out_valid && in_ready) rdy_viol++;
    end
    bp_ctr++;
    out_ready = bp ? ((bp_ctr % 3) != 0) : 1'b1;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; bp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_word(logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(logic [31:0] w0, w1, w2, w3, w6);
    send_word(w0); send_word(w1); send_word(w2); send_word(w3);
    send_word(32'h0); send_word(32'h0); send_word(w6); send_word(32'h0);
  endtask

  task automatic send_global(logic [31:0] isp, tsp, tex, bit gour, logic [1:0] colt, logic [2:0] lst);
    send_pkt((32'd4 << 29) | (32'(lst) << 24) | (32'(colt) << 4) | (32'(gour) << 1),
             isp, tsp, tex, 32'h0);
  endtask

  task automatic send_vertex(int id, bit eos);
    send_pkt((32'd7 << 29) | (32'(eos) << 28), 32'(id), 32'(id + 100),
             32'(id + 200), 32'hC000_0000 | 32'(id));
  endtask

  task automatic send_strip(int base, int n, bit close);
    for (int i = 0; i < n; i++) send_vertex(base + i, close && (i == n - 1));
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  // reference split model: chunks of up to 8 vertices, seam repeats two
  task automatic model_strip(int base, int n);
    int s = 0, e;
    forever begin
      e = (s + 7 < n - 1) ? s + 7 : n - 1;
      for (int i = s; i <= e; i++) begin
        e_id[ne] = base + i; e_last[ne] = (i == e); ne++;
      end
      if (e == n - 1) break;
      s = e - 1;
    end
  endtask

  task automatic compare(string req, int from, int cnt, logic [31:0] isp, tsp, tex, logic [2:0] lst);
    for (int i = 0; i < cnt; i++) begin
      int k = from + i;
      chk(g_x[k] == 32'(e_id[k]), req, g_x[k], 32'(e_id[k]));
      chk(g_last[k] == e_last[k], req, 32'(g_last[k]), 32'(e_last[k]));
      chk(g_y[k] == g_x[k] + 100 && g_z[k] == g_x[k] + 200 &&
          g_c[k] == (32'hC000_0000 | g_x[k]), "R6 fields", g_c[k], 32'hC000_0000 | g_x[k]);
      chk(g_isp[k] == isp && g_tsp[k] == tsp && g_tex[k] == tex, "R3 words", g_isp[k], isp);
      chk(g_list[k] == lst, "R3 list", 32'(g_list[k]), 32'(lst));
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(in_ready == 1'b1, "R12 in_ready", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R12 out_valid", 32'(out_valid), 32'd0);
    chk(list_done == 1'b0 && err == 1'b0, "R12 done/err", 32'({list_done, err}), 32'd0);
  endtask

  task automatic t_short_shade();
    nb = 0; ne = 0;
    send_global(32'h0080_0055, 32'h1234, 32'h5678, 1'b0, 2'd0, 3'd2);
    send_strip(0, 3, 1'b1); drain();
    model_strip(0, 3);
    chk(nb == 3, "R7 beat count", 32'(nb), 32'd3);
    compare("R7 R4 short strip", 0, 3, 32'h0000_0055, 32'h1234, 32'h5678, 3'd2);
    send_global(32'h0000_0055, 32'h1, 32'h2, 1'b1, 2'd0, 3'd0);
    send_strip(10, 3, 1'b1); drain();
    model_strip(10, 3);
    chk(nb == 6, "R4 beat count", 32'(nb), 32'd6);
    compare("R4 shade set", 3, 3, 32'h0080_0055, 32'h1, 32'h2, 3'd0);
  endtask

  task automatic t_long(int base, int n);
    nb = 0; ne = 0; bp = 1'b1; rdy_viol = 0;
    send_strip(base, n, 1'b1); drain(); bp = 1'b0;
    model_strip(base, n);
    chk(nb == ne, "R8 beat count", 32'(nb), 32'(ne));
    compare("R8 split", 0, (nb < ne) ? nb : ne, 32'h0080_0055, 32'h1, 32'h2, 3'd0);
    chk(rdy_viol == 0, "R11 in_ready while out_valid", 32'(rdy_viol), 32'd0);
  endtask

  task automatic t_midglobal();
    nb = 0; ne = 0;
    send_global(32'h0000_00AA, 32'h3, 32'h4, 1'b0, 2'd0, 3'd1);
    send_strip(60, 2, 1'b0);
    send_global(32'h0000_00BB, 32'h5, 32'h6, 1'b0, 2'd0, 3'd1);
    send_strip(62, 3, 1'b1); drain();
    model_strip(60, 2); model_strip(62, 3);
    chk(nb == 5, "R9 beat count", 32'(nb), 32'd5);
    compare("R9 old words", 0, 2, 32'h0000_00AA, 32'h3, 32'h4, 3'd1);
    compare("R9 new words", 2, 3, 32'h0000_00BB, 32'h5, 32'h6, 3'd1);
  endtask

  task automatic t_eol();
    nb = 0; ne = 0; done_cnt = 0;
    send_strip(70, 3, 1'b0);
    send_pkt(32'h0, 32'h0, 32'h0, 32'h0, 32'h0); drain();
    model_strip(70, 3);
    chk(nb == 3, "R10 flush count", 32'(nb), 32'd3);
    compare("R10 flush", 0, 3, 32'h0000_00BB, 32'h5, 32'h6, 3'd1);
    chk(done_cnt == 1, "R10 list_done one cycle", 32'(done_cnt), 32'd1);
    chk(err == 1'b0, "R10 no err yet", 32'(err), 32'd0);
    send_vertex(90, 1'b1); drain();
    chk(err == 1'b1 && nb == 3, "R10 global cleared", 32'({err, 8'(nb)}), 32'h103);
  endtask

  task automatic t_badtype();
    do_reset(); nb = 0; ne = 0;
    send_global(32'h0, 32'h7, 32'h8, 1'b0, 2'd0, 3'd0);
    send_pkt(32'd2 << 29, 32'h0, 32'h0, 32'h0, 32'h0); drain();
    chk(err == 1'b1 && nb == 0, "R2 unknown type", 32'({err, 8'(nb)}), 32'h100);
    send_strip(80, 3, 1'b1); drain();
    model_strip(80, 3);
    chk(nb == 3, "R1 framing kept", 32'(nb), 32'd3);
    compare("R1 after drop", 0, 3, 32'h0, 32'h7, 32'h8, 3'd0);
  endtask

  task automatic t_colour();
    do_reset(); nb = 0; ne = 0;
    send_global(32'h0000_0011, 32'h9, 32'hA, 1'b0, 2'd0, 3'd0);
    send_global(32'h0000_0022, 32'hB, 32'hC, 1'b1, 2'd1, 3'd3); drain();
    chk(err == 1'b1, "R5 colour type err", 32'(err), 32'd1);
    send_strip(100, 3, 1'b1); drain();
    model_strip(100, 3);
    chk(nb == 3, "R5 beat count", 32'(nb), 32'd3);
    compare("R5 old global kept", 0, 3, 32'h0000_0011, 32'h9, 32'hA, 3'd0);
  endtask

  task automatic t_nogloal();
    do_reset(); nb = 0;
    send_vertex(5, 1'b1); drain();
    chk(err == 1'b1 && nb == 0, "R6 vertex before global", 32'({err, 8'(nb)}), 32'h100);
  endtask

  initial begin
    t_reset();
    t_short_shade();
    t_long(20, 10);
    t_long(40, 16);
    t_midglobal();
    t_eol();
    t_badtype();
    t_colour();
    t_nogloal();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule